// File: doc/BRIEF.md
# Split-Word IRQ/FIQ Interrupt Controller

This block gathers 51 level interrupt sources into a latched status vector, masks that vector with a per-source enable, and steers each active source to one of two outputs. A source whose select bit is set drives the fast interrupt line. A source whose select bit is clear drives the normal interrupt line. Each source has one bit in several 51-bit logical registers. Software reaches these registers over a 32-bit register port, and each logical register appears there as a low word and a high word.

The enable and trigger vectors each have a set address and a clear address. Writing a 1 to a bit at the set address sets that bit, and writing a 1 at the clear address clears it, so one driver can change one source's bit without a read-modify-write. The select vector is written one half at a time. The sense, dual-edge and event vectors are fixed descriptors. Only a narrow field of the event vector is writable, and that field lies above the reach of the high word.

The source inputs pass through a two-flop synchronizer. A rising level on a source sets its status bit and a falling level clears it. Software can also clear status bits. Read data is registered, and so are both interrupt lines.

Top module: `split_word_intc`

## Requirements
- R1: A source input that goes high sets its status bit on the third rising clock edge after the change, and a source input that goes low clears it on the third edge. The status bit is bit n of the raw status word at offset 0x10 and of the status word at offset 0x60.
- R2: Address bit 2 selects the high word of a logical register. In the high word, data bits 0..14 map to register bits 32..46. Reads of the high word return zero in data bits 15..31, and writes ignore those data bits.
- R3: Writing a 1 to a bit at offset 0x20 sets that enable bit, and writing a 1 at offset 0x28 clears it. Offsets 0x30 and 0x38 do the same for the trigger vector. Zero bits written at any of these offsets change nothing. Reads at 0x20 return the enable vector and reads at 0x30 return the trigger vector.
- R4: A write to the select register at 0x18 (low word) or 0x1C (high word) replaces that half and leaves the other half unchanged.
- R5: Writing a 1 to a bit at offset 0x58 clears that status bit, even while the source input is still high. If a synchronized edge on the same source arrives in the same cycle, the edge wins.
- R6: Offset 0x00 reads status & enable & ~select. Offset 0x08 reads status & enable & select.
- R7: The output irq_o equals the OR of status & enable & ~select, and fiq_o equals the OR of status & enable & select, each taken one clock earlier.
- R8: After reset, select, enable, trigger and status are zero and both outputs are low. Sense reads 0x1F07_FFF8FFFF, dual-edge reads 0x00F8_00070000 and event reads 0x5F07_FFF8FFFF.
- R9: Only event bits 47..50 are writable. Because the high word carries only bits 32..46, event reads (0x50/0x54) stay at their reset values after any write.
- R10: Reads of 0x28, 0x38 and 0x58 return zero. Writes to 0x00, 0x08, 0x10, 0x40, 0x48 and 0x60 (or to their high words) change no register.
- R11: The block ignores any access with an address above 0x64, an address with bits 1..0 non-zero, or a size code other than 2'b10 (a 32-bit word). Such a read returns zero and such a write changes nothing.
- R12: bus_rdata is loaded on the clock edge that accepts a read and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NUM_SRC | Interrupt source levels, asynchronous |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_size | input | 2 | Access size code, 2'b10 = 32-bit |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The bench builds the block with its default parameters: 51 sources, a 15-bit high word, a 12-bit address and a 4-bit event field at bits 47..50. With the high word this narrow, sources 47..50 and the writable event field cannot be reached, so the bench confirms that event reads stay fixed. The 12-bit address allows aliased offsets with high address bits set, which must be rejected. Sources placed in both halves (bits 3 and 40) exercise half-wise select, enable and status handling. The bench compares a behavioural model against the read data and both interrupt lines on every cycle.

// File: rtl/swic_pkg.sv
package swic_pkg;

    localparam logic [1:0] SZ_WORD = 2'b10;

    localparam logic [63:0] SENSE_RST = 64'h0000_1F07_FFF8_FFFF;
    localparam logic [63:0] DUAL_RST  = 64'h0000_00F8_0007_0000;
    localparam logic [63:0] EVENT_RST = 64'h0000_5F07_FFF8_FFFF;

    // register pair index = byte offset >> 3; the order is the address map
    typedef enum logic [3:0] {
        RG_IRQ_ST = 4'd0,
        RG_FIQ_ST = 4'd1,
        RG_RAW    = 4'd2,
        RG_SEL    = 4'd3,
        RG_EN_SET = 4'd4,
        RG_EN_CLR = 4'd5,
        RG_TR_SET = 4'd6,
        RG_TR_CLR = 4'd7,
        RG_SENSE  = 4'd8,
        RG_DUAL   = 4'd9,
        RG_EVENT  = 4'd10,
        RG_ST_CLR = 4'd11,
        RG_STATUS = 4'd12,
        RG_NONE   = 4'd15
    } rg_e;

    function automatic rg_e rg_decode(input int unsigned idx);
        if (idx <= 12) return rg_e'(idx[3:0]);
        return RG_NONE;
    endfunction

endpackage

// File: rtl/swic_sync.sv
module swic_sync #(
    parameter int N      = 51,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] stg [STAGES];
    logic [N-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
            prev_q <= '0;
        end else begin
            stg[0] <= async_in;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            prev_q <= stg[STAGES-1];
        end
    end

    assign rise = stg[STAGES-1] & ~prev_q;
    assign fall = ~stg[STAGES-1] & prev_q;
endmodule

// File: rtl/swic_regbank.sv
module swic_regbank
    import swic_pkg::*;
#(
    parameter int N       = 51,
    parameter int ADDR_W  = 12,
    parameter int BUS_W   = 32,
    parameter int HI_BITS = 15,
    parameter int EV_LO   = 47,
    parameter int EV_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      rise,
    input  logic [N-1:0]      fall,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [N-1:0]      status_q,
    output logic [N-1:0]      enable_q,
    output logic [N-1:0]      select_q,
    output logic [BUS_W-1:0]  bus_rdata
);
    localparam logic [N-1:0] LO_MASK = {{(N-BUS_W){1'b0}}, {BUS_W{1'b1}}};
    localparam logic [N-1:0] HI_MASK = {{(N-HI_BITS){1'b0}}, {HI_BITS{1'b1}}} << BUS_W;
    localparam logic [N-1:0] SENSE_V = SENSE_RST[N-1:0];
    localparam logic [N-1:0] DUAL_V  = DUAL_RST[N-1:0];
    localparam logic [N-1:0] EVENT_V = EVENT_RST[N-1:0];

    logic            hi_half;
    logic            acc_ok;
    logic            wr_fire;
    rg_e             kind;
    logic [N-1:0]    wd_full;
    logic [N-1:0]    half_mask;
    logic [N-1:0]    trigger_q;
    logic [EV_W-1:0] ev_q;
    logic [N-1:0]    ev_full;
    logic [N-1:0]    sel_d, en_d, tr_d, st_clr;
    logic [EV_W-1:0] ev_d;
    logic [N-1:0]    rv;
    logic [BUS_W-1:0] rd_word;

    assign hi_half   = bus_addr[2];
    assign acc_ok    = bus_valid && (bus_size == SZ_WORD) && (bus_addr[1:0] == 2'b00);
    assign kind      = acc_ok ? rg_decode(int'(bus_addr[ADDR_W-1:3])) : RG_NONE;
    assign wr_fire   = acc_ok && bus_write;
    assign half_mask = hi_half ? HI_MASK : LO_MASK;
    assign wd_full   = hi_half ? ({{(N-HI_BITS){1'b0}}, bus_wdata[HI_BITS-1:0]} << BUS_W)
                               : {{(N-BUS_W){1'b0}}, bus_wdata};

    always_comb begin
        ev_full = EVENT_V;
        ev_full[EV_LO +: EV_W] = ev_q;
    end

    // next-state for the writable vectors
    always_comb begin
        sel_d  = select_q;
        en_d   = enable_q;
        tr_d   = trigger_q;
        ev_d   = ev_q;
        st_clr = '0;
        if (wr_fire) begin
            unique case (kind)
                RG_SEL:    sel_d  = (select_q & ~half_mask) | wd_full;
                RG_EN_SET: en_d   = enable_q | wd_full;
                RG_EN_CLR: en_d   = enable_q & ~wd_full;
                RG_TR_SET: tr_d   = trigger_q | wd_full;
                RG_TR_CLR: tr_d   = trigger_q & ~wd_full;
                RG_EVENT:  ev_d   = wd_full[EV_LO +: EV_W];
                RG_ST_CLR: st_clr = wd_full;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            select_q  <= '0;
            enable_q  <= '0;
            trigger_q <= '0;
            status_q  <= '0;
            ev_q      <= EVENT_V[EV_LO +: EV_W];
        end else begin
            select_q  <= sel_d;
            enable_q  <= en_d;
            trigger_q <= tr_d;
            ev_q      <= ev_d;
            status_q  <= ((status_q & ~st_clr) | rise) & ~fall;
        end
    end

    // read mux
    always_comb begin
        unique case (kind)
            RG_IRQ_ST: rv = status_q & enable_q & ~select_q;
            RG_FIQ_ST: rv = status_q & enable_q & select_q;
            RG_RAW:    rv = status_q;
            RG_SEL:    rv = select_q;
            RG_EN_SET: rv = enable_q;
            RG_TR_SET: rv = trigger_q;
            RG_SENSE:  rv = SENSE_V;
            RG_DUAL:   rv = DUAL_V;
            RG_EVENT:  rv = ev_full;
            RG_STATUS: rv = status_q;
            default:   rv = '0;
        endcase
        rd_word = hi_half ? {{(BUS_W-HI_BITS){1'b0}}, rv[BUS_W +: HI_BITS]}
                          : rv[BUS_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       bus_rdata <= '0;
        else if (bus_valid && !bus_write) bus_rdata <= rd_word;
    end

    // R1: a synchronized rising edge lands in status
    assert_rise_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise) |=> ((status_q & $past(rise)) == $past(rise)));
    // R1: a synchronized falling edge clears status
    assert_fall_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (|fall) |=> ((status_q & $past(fall)) == '0));
    // R3: clear address removes the written bits from enable
    assert_en_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && kind == RG_EN_CLR) |=> ((enable_q & $past(wd_full)) == '0));
    // R4: select half write keeps the other half
    assert_sel_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && kind == RG_SEL) |=>
        ((select_q & ~$past(half_mask)) == ($past(select_q) & ~$past(half_mask))));
    // R10: write-only offsets read as zero
    assert_wo_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && (kind == RG_EN_CLR || kind == RG_TR_CLR || kind == RG_ST_CLR))
        |=> (bus_rdata == '0));
    // R11: reads of a wrong size return zero
    assert_bad_size_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_size != SZ_WORD) |=> (bus_rdata == '0));
endmodule

// File: rtl/swic_outstage.sv
module swic_outstage #(
    parameter int N = 51
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] status_q,
    input  logic [N-1:0] enable_q,
    input  logic [N-1:0] select_q,
    output logic         irq_o,
    output logic         fiq_o
);
    logic [N-1:0] live;
    assign live = status_q & enable_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
            fiq_o <= 1'b0;
        end else begin
            irq_o <= |(live & ~select_q);
            fiq_o <= |(live & select_q);
        end
    end
endmodule

// File: rtl/split_word_intc.sv
module split_word_intc #(
    parameter int NUM_SRC = 51,
    parameter int ADDR_W  = 12,
    parameter int HI_BITS = 15,
    parameter int EV_LO   = 47,
    parameter int EV_W    = 4,
    parameter int SYNC_N  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [1:0]         bus_size,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               irq_o,
    output logic               fiq_o
);
    localparam int BUS_W = 32;

    logic [NUM_SRC-1:0] rise, fall;
    logic [NUM_SRC-1:0] status_q, enable_q, select_q;

    swic_sync #(.N(NUM_SRC), .STAGES(SYNC_N)) sync_i (
        .clk(clk), .rst_n(rst_n), .async_in(src_in), .rise(rise), .fall(fall)
    );

    swic_regbank #(
        .N(NUM_SRC), .ADDR_W(ADDR_W), .BUS_W(BUS_W),
        .HI_BITS(HI_BITS), .EV_LO(EV_LO), .EV_W(EV_W)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata),
        .status_q(status_q), .enable_q(enable_q), .select_q(select_q),
        .bus_rdata(bus_rdata)
    );

    swic_outstage #(.N(NUM_SRC)) out_i (
        .clk(clk), .rst_n(rst_n), .status_q(status_q), .enable_q(enable_q),
        .select_q(select_q), .irq_o(irq_o), .fiq_o(fiq_o)
    );

    // R7: with nothing enabled, both lines are low one clock later
    assert_out_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_q == '0) |=> (!irq_o && !fiq_o));
    // R7: a raised fast line traces back to a selected, enabled, pending source
    assert_fiq_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fiq_o) |-> ($past(status_q & enable_q & select_q) != '0));
endmodule

// File: tb/split_word_intc_tb.sv
module split_word_intc_tb_top;
    localparam int N = 51;
    localparam logic [63:0] M51 = (64'd1 << N) - 64'd1;
    localparam logic [63:0] EVW = 64'h0007_8000_0000_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] src = '0;
    logic bv = 1'b0, bw = 1'b0;
    logic [11:0] ba = '0;
    logic [1:0] bs = 2'b10;
    logic [31:0] bd = '0;
    logic [31:0] rdata;
    logic irq, fiq;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    split_word_intc dut_i (
        .clk(clk), .rst_n(rst_n), .src_in(src), .bus_valid(bv), .bus_write(bw),
        .bus_addr(ba), .bus_size(bs), .bus_wdata(bd), .bus_rdata(rdata),
        .irq_o(irq), .fiq_o(fiq)
    );

    // behavioural reference model
    logic [63:0] m_s1, m_s2, m_s3, m_st, m_en, m_sel, m_tr, m_ev;
    logic [31:0] m_rd;
    logic m_irq, m_fiq;

    function automatic logic [31:0] mread(input logic [11:0] a, input logic [1:0] sz);
        logic [63:0] v;
        if (sz != 2'b10 || a[1:0] != 2'b00 || a > 12'h064) return 32'h0;
        case (a & 12'hFF8)
            12'h000: v = m_st & ~m_sel & m_en;
            12'h008: v = m_st & m_sel & m_en;
            12'h010: v = m_st;
            12'h018: v = m_sel;
            12'h020: v = m_en;
            12'h030: v = m_tr;
            12'h040: v = 64'h0000_1F07_FFF8_FFFF;
            12'h048: v = 64'h0000_00F8_0007_0000;
            12'h050: v = m_ev;
            12'h060: v = m_st;
            default: v = 64'h0;
        endcase
        if (a[2]) return 32'((v >> 32) & 64'h7FFF);
        return v[31:0];
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_s3 = 0; m_st = 0; m_en = 0; m_sel = 0; m_tr = 0;
            m_ev = 64'h0000_5F07_FFF8_FFFF; m_rd = 0; m_irq = 0; m_fiq = 0;
        end else begin
            logic [63:0] rs, fl, dd, clr, n_st;
            logic ok;
            rs  = m_s2 & ~m_s3;
            fl  = ~m_s2 & m_s3;
            clr = 0;
            m_irq = |(m_st & m_en & ~m_sel & M51);
            m_fiq = |(m_st & m_en & m_sel & M51);
            if (bv && !bw) m_rd = mread(ba, bs);
            ok = bv && bw && bs == 2'b10 && ba[1:0] == 2'b00 && ba <= 12'h064;
            dd = ba[2] ? ((64'(bd) & 64'h7FFF) << 32) : 64'(bd);
            if (ok) begin
                case (ba & 12'hFF8)
                    12'h018: m_sel = ba[2] ? ((m_sel & 64'hFFFF_FFFF) | dd)
                                           : ((m_sel & (64'h7FFF << 32)) | dd);
                    12'h020: m_en = m_en | dd;
                    12'h028: m_en = m_en & ~dd;
                    12'h030: m_tr = m_tr | dd;
                    12'h038: m_tr = m_tr & ~dd;
                    12'h050: m_ev = (m_ev & ~EVW) | (dd & EVW);
                    12'h058: clr = dd;
                    default: ;
                endcase
            end
            n_st = ((m_st & ~clr) | rs) & ~fl;
            m_st = n_st & M51;
            m_s3 = m_s2;
            m_s2 = m_s1;
            m_s1 = 64'(src);
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R12 rdata vs model", rdata, m_rd);
            check("R7 irq vs model", {31'b0, irq}, {31'b0, m_irq});
            check("R7 fiq vs model", {31'b0, fiq}, {31'b0, m_fiq});
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [1:0] sz = 2'b10);
        @(negedge clk);
        bv = 1'b1; bw = 1'b1; ba = a; bd = d; bs = sz;
        @(negedge clk);
        bv = 1'b0; bw = 1'b0; bs = 2'b10;
    endtask

    task automatic rd(input string tag, input logic [11:0] a, input logic [31:0] exp,
                      input logic [1:0] sz = 2'b10);
        @(negedge clk);
        bv = 1'b1; bw = 1'b0; ba = a; bs = sz;
        @(negedge clk);
        bv = 1'b0; bs = 2'b10;
        check(tag, rdata, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R8 reset state
        check("R8 irq reset", {31'b0, irq}, 32'h0);
        check("R8 fiq reset", {31'b0, fiq}, 32'h0);
        rd("R8 sense lo", 12'h040, 32'hFFF8_FFFF);
        rd("R8 sense hi", 12'h044, 32'h0000_1F07);
        rd("R8 dual lo", 12'h048, 32'h0007_0000);
        rd("R8 dual hi", 12'h04C, 32'h0000_00F8);
        rd("R8 event lo", 12'h050, 32'hFFF8_FFFF);
        rd("R8 event hi", 12'h054, 32'h0000_5F07);
        rd("R8 enable", 12'h020, 32'h0);
        rd("R8 select", 12'h018, 32'h0);
        // R1 sources in both halves
        src[3] = 1'b1; src[40] = 1'b1;
        idle(4);
        rd("R1 raw lo", 12'h010, 32'h0000_0008);
        rd("R1 raw hi", 12'h014, 32'h0000_0100);
        // R3 enable set, R7 output
        wr(12'h020, 32'h0000_0008);
        idle(1);
        check("R7 irq after enable", {31'b0, irq}, 32'h1);
        rd("R3 enable readback", 12'h020, 32'h0000_0008);
        rd("R6 irq status lo", 12'h000, 32'h0000_0008);
        rd("R6 fiq status lo", 12'h008, 32'h0);
        // R4 select halves, R2 high-word window
        wr(12'h018, 32'h0000_0008);
        idle(1);
        check("R7 fiq after select", {31'b0, fiq}, 32'h1);
        check("R7 irq after select", {31'b0, irq}, 32'h0);
        wr(12'h01C, 32'hFFFF_FFFF);
        rd("R2 select hi masked", 12'h01C, 32'h0000_7FFF);
        rd("R4 select lo kept", 12'h018, 32'h0000_0008);
        wr(12'h018, 32'h0);
        rd("R4 select hi kept", 12'h01C, 32'h0000_7FFF);
        // enable high word
        wr(12'h024, 32'h0000_0100);
        rd("R6 fiq status hi", 12'h00C, 32'h0000_0100);
        rd("R6 irq status lo again", 12'h000, 32'h0000_0008);
        rd("R6 irq status hi", 12'h004, 32'h0);
        // R3 clears
        wr(12'h028, 32'h0000_0008);
        rd("R3 enable cleared", 12'h020, 32'h0);
        wr(12'h030, 32'h0000_00A5);
        rd("R3 trigger set", 12'h030, 32'h0000_00A5);
        wr(12'h038, 32'h0000_0005);
        rd("R3 trigger clear", 12'h030, 32'h0000_00A0);
        // R5 status clear while input high
        wr(12'h058, 32'h0000_0008);
        rd("R5 raw lo cleared", 12'h010, 32'h0);
        rd("R5 status lo cleared", 12'h060, 32'h0);
        // R1 falling input
        src[40] = 1'b0;
        idle(5);
        check("R1 fiq drops", {31'b0, fiq}, 32'h0);
        rd("R1 raw hi cleared", 12'h014, 32'h0);
        // R10 write-only reads, read-only writes
        rd("R10 enable clear reads zero", 12'h028, 32'h0);
        rd("R10 status clear reads zero", 12'h05C, 32'h0);
        wr(12'h040, 32'h0);
        wr(12'h010, 32'hFFFF_FFFF);
        rd("R10 sense unchanged", 12'h040, 32'hFFF8_FFFF);
        rd("R10 raw unchanged", 12'h010, 32'h0);
        // R9 event
        wr(12'h054, 32'hFFFF_FFFF);
        rd("R9 event hi fixed", 12'h054, 32'h0000_5F07);
        wr(12'h050, 32'h0);
        rd("R9 event lo fixed", 12'h050, 32'hFFF8_FFFF);
        // R11 ignored accesses
        wr(12'h020, 32'h0000_00FF, 2'b01);
        rd("R11 bad-size write ignored", 12'h020, 32'h0);
        wr(12'h020, 32'h0000_0003);
        rd("R11 bad-size read zero", 12'h020, 32'h0, 2'b01);
        rd("R3 enable set again", 12'h020, 32'h0000_0003);
        rd("R11 beyond range", 12'h068, 32'h0);
        rd("R11 unaligned", 12'h022, 32'h0);
        rd("R11 aliased high address", 12'h120, 32'h0);
        wr(12'h120, 32'h0000_0004);
        rd("R11 aliased write ignored", 12'h020, 32'h0000_0003);
        // R2 high write bits above 14 ignored
        wr(12'h01C, 32'hFFFF_8000);
        rd("R2 upper data dropped", 12'h01C, 32'h0);
        // R12 hold
        idle(3);
        check("R12 rdata held", rdata, 32'h0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule